// File: doc/BRIEF.md
# Entropy word cache with prefetch

This block sits between a processor's register-read path and an external entropy source that hands over one 32-bit word per transaction. It holds exactly one 256-bit random value. The value is built from eight consecutive transactions. The first word received lands in the least significant 32 bits, and each later word goes into the next slot up.

The processor side has one read request. A width select chooses between the full 256-bit value and a 32-bit read of the low word only. A read served from a full cache completes in the same cycle and empties the cache. A read issued against an empty cache raises a combinational stall until a fill completes. A separate prefetch request starts a fill ahead of need, so that the source latency can be hidden.

An operation-start pulse throws away whatever is cached. If a fill is in flight at that moment, its remaining words are counted off and dropped. A fresh fill can only begin after those words have been absorbed.

Top module: `entropy_cache`

## Requirements
- R1: After reset the cache is empty, `src_req_o` and `rd_grant_o` are low, `rd_data_o` is zero, and `rd_stall_o` is low while no read is requested.
- R2: Within a fill, the k-th accepted word (k = 0 first) is stored at bits [32k+31:32k] of the 256-bit value.
- R3: A fill starts on the clock edge at which it is requested. It holds `src_req_o` high from the next cycle until eight words have been accepted, with each cycle having `src_ack_i` high accepting one word. `src_req_o` is low in the cycle after the eighth word.
- R4: A read (`rd_req_i` high) with an empty cache drives `rd_stall_o` high in the same cycle and starts a fill if none is running. The read is granted in the cycle after the eighth word is accepted.
- R5: A read with a full cache is granted in the same cycle without stalling. The cache is empty from the next cycle on.
- R6: With `rd_narrow_i` = 1, a granted read returns the low 32 bits of the cached value in `rd_data_o[31:0]` and zero above. With `rd_narrow_i` = 0 it returns the whole 256-bit value.
- R7: `prefetch_i` starts a fill only when the cache is empty and no fill is running. Otherwise it has no effect: no extra words are requested and the cached value is unchanged.
- R8: A read that stalls while a prefetch fill is running waits for that same fill. It is granted after that fill's eighth word, with no further words requested.
- R9: An `op_start_i` pulse empties a full cache, so the next read stalls and receives a newly filled value.
- R10: An `op_start_i` pulse during a fill drops that fill. Its remaining words are still accepted, but they are neither stored nor delivered. A new fill requested meanwhile starts only after the dropped fill's eighth word.
- R11: `rd_data_o` is zero in every cycle without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_start_i | input | 1 | Operation start: discard cached and in-flight entropy |
| prefetch_i | input | 1 | Request a fill ahead of a read |
| rd_req_i | input | 1 | Processor read request |
| rd_narrow_i | input | 1 | 1 = 32-bit read of the low word, 0 = full-width read |
| rd_stall_o | output | 1 | Read must wait (cache empty) |
| rd_grant_o | output | 1 | Read served this cycle |
| rd_data_o | output | 256 | Read value, zero when not granted |
| src_req_o | output | 1 | Request to the entropy source |
| src_ack_i | input | 1 | Entropy word valid this cycle |
| src_data_i | input | 32 | Entropy word |

## Verification
The bench times the grant of a stalled read to the cycle right after the eighth word. A design that set the valid flag one edge late, or that granted on the last word itself, would fail that check. Word placement is checked with distinct per-slot values, which catches a reversed or shifted assembly order. Prefetches issued while the cache is full or busy must leave the source request low and the stored value intact. A design that restarted or overwrote the fill would either raise the request or return the wrong value. An operation start in the middle of a fill must not let the drained words through, and must not start a new fill before the old one has finished. A design that reset the word counter, or that stored drained words, would return stale entropy or raise the request early.

// File: rtl/entropy_cache_pkg.sv
package entropy_cache_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DROP = 2'd2
  } fill_state_e;
endpackage

// File: rtl/entropy_cache_ctrl.sv
module entropy_cache_ctrl
  import entropy_cache_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_start_i,
  input  logic             prefetch_i,
  input  logic             rd_req_i,
  input  logic             src_ack_i,
  output logic             src_req_o,
  output logic             store_en_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             valid_o,
  output logic             grant_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORDS - 1);

  fill_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             ack_take, last_word, fill_start, fill_done;

  assign ack_take   = src_ack_i && (state_q != FILL_IDLE);
  assign last_word  = (cnt_q == LAST_SLOT);
  assign fill_start = (prefetch_i || rd_req_i) && !valid_q && !op_start_i;
  assign grant_o    = rd_req_i && valid_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    fill_done = 1'b0;
    unique case (state_q)
      FILL_IDLE: begin
        if (fill_start) begin
          state_d = FILL_RUN;
          cnt_d   = '0;
        end
      end
      FILL_RUN: begin
        if (ack_take) begin
          cnt_d = last_word ? '0 : cnt_q + 1'b1;
          if (last_word) begin
            state_d   = FILL_IDLE;
            fill_done = !op_start_i;
          end
        end
        if (op_start_i && !(ack_take && last_word)) state_d = FILL_DROP;
      end
      FILL_DROP: begin
        if (ack_take) begin
          cnt_d = last_word ? '0 : cnt_q + 1'b1;
          if (last_word) state_d = FILL_IDLE;
        end
      end
      default: state_d = FILL_IDLE;
    endcase
  end

  always_comb begin
    valid_d = valid_q;
    if (op_start_i)     valid_d = 1'b0;
    else if (fill_done) valid_d = 1'b1;
    else if (grant_o)   valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign src_req_o  = (state_q != FILL_IDLE);
  assign store_en_o = ack_take && (state_q == FILL_RUN) && !op_start_i;
  assign slot_o     = cnt_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/entropy_cache_asm.sv
module entropy_cache_asm #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int VAL_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_en_i,
  input  logic [CNT_W-1:0]  slot_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [VAL_W-1:0]  value_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = store_en_i && (slot_i == CNT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= word_i;
      end
    end

    assign value_o[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/entropy_cache_port.sv
module entropy_cache_port #(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 256
) (
  input  logic             grant_i,
  input  logic             narrow_i,
  input  logic [VAL_W-1:0] value_i,
  output logic [VAL_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (grant_i) begin
      if (narrow_i) data_o[WORD_W-1:0] = value_i[WORD_W-1:0];
      else          data_o             = value_i;
    end
  end
endmodule

// File: rtl/entropy_cache.sv
module entropy_cache #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int VAL_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              prefetch_i,
  input  logic              rd_req_i,
  input  logic              rd_narrow_i,
  output logic              rd_stall_o,
  output logic              rd_grant_o,
  output logic [VAL_W-1:0]  rd_data_o,
  output logic              src_req_o,
  input  logic              src_ack_i,
  input  logic [WORD_W-1:0] src_data_i
);
  logic             store_en;
  logic [CNT_W-1:0] slot;
  logic             cache_valid;
  logic [VAL_W-1:0] value;

  entropy_cache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_start_i (op_start_i),
    .prefetch_i (prefetch_i),
    .rd_req_i   (rd_req_i),
    .src_ack_i  (src_ack_i),
    .src_req_o  (src_req_o),
    .store_en_o (store_en),
    .slot_o     (slot),
    .valid_o    (cache_valid),
    .grant_o    (rd_grant_o)
  );

  entropy_cache_asm #(.WORD_W(WORD_W), .WORDS(WORDS)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .store_en_i (store_en),
    .slot_i     (slot),
    .word_i     (src_data_i),
    .value_o    (value)
  );

  entropy_cache_port #(.WORD_W(WORD_W), .VAL_W(VAL_W)) u_port (
    .grant_i  (rd_grant_o),
    .narrow_i (rd_narrow_i),
    .value_i  (value),
    .data_o   (rd_data_o)
  );

  assign rd_stall_o = rd_req_i && !cache_valid;
endmodule

// File: rtl/entropy_cache_chk.sv
module entropy_cache_chk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int VAL_W = WORD_W * WORDS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_start_i,
  input logic             prefetch_i,
  input logic             rd_req_i,
  input logic             rd_narrow_i,
  input logic             rd_stall_o,
  input logic             rd_grant_o,
  input logic [VAL_W-1:0] rd_data_o,
  input logic             src_req_o,
  input logic             src_ack_i
);
  // R3
  req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_req_o && !prefetch_i && !rd_req_i) |=> !src_req_o);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_req_o && !src_ack_i && !op_start_i) |=> src_req_o);
  // R4
  stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stall_o |-> (rd_req_i && !rd_grant_o));
  // R5
  consume_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_grant_o |=> !rd_grant_o);
  // R6
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_grant_o && rd_narrow_i) |-> (rd_data_o[VAL_W-1:WORD_W] == '0));
  // R7
  full_no_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_grant_o |-> !src_req_o);
  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |=> !rd_grant_o);
  // R11
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_grant_o |-> (rd_data_o == '0));
endmodule

bind entropy_cache entropy_cache_chk #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_start_i  (op_start_i),
  .prefetch_i  (prefetch_i),
  .rd_req_i    (rd_req_i),
  .rd_narrow_i (rd_narrow_i),
  .rd_stall_o  (rd_stall_o),
  .rd_grant_o  (rd_grant_o),
  .rd_data_o   (rd_data_o),
  .src_req_o   (src_req_o),
  .src_ack_i   (src_ack_i)
);

// File: tb/entropy_cache_tb.sv
module entropy_cache_tb;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int VAL_W  = WORD_W * WORDS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, op_start, prefetch, rd_req, rd_narrow;
  logic              rd_stall, rd_grant, src_req, src_ack;
  logic [VAL_W-1:0]  rd_data;
  logic [WORD_W-1:0] src_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  entropy_cache #(.WORD_W(WORD_W), .WORDS(WORDS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .prefetch_i(prefetch),
    .rd_req_i(rd_req), .rd_narrow_i(rd_narrow), .rd_stall_o(rd_stall),
    .rd_grant_o(rd_grant), .rd_data_o(rd_data), .src_req_o(src_req),
    .src_ack_i(src_ack), .src_data_i(src_data)
  );

  // {use_prefetch, narrow, seed}
  localparam logic [33:0] VEC [4] = '{
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b0, 1'b0, 32'hA5A5_0F0F},
    {1'b1, 1'b1, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 32'h0BAD_F00D}
  };

  function automatic logic [WORD_W-1:0] wgen(logic [31:0] s, int k);
    return s ^ 32'(32'h9E37_79B9 * 32'(k + 1)) ^ 32'(k << 24);
  endfunction

  function automatic logic [VAL_W-1:0] vgen(logic [31:0] s);
    logic [VAL_W-1:0] v;
    for (int k = 0; k < WORDS; k++) v[k*WORD_W +: WORD_W] = wgen(s, k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [VAL_W-1:0] act, input logic [VAL_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [31:0] seed, input int n, input int first);
    for (int k = first; k < first + n; k++) begin
      @(negedge clk);
      src_ack  = 1'b1;
      src_data = wgen(seed, k);
    end
    @(negedge clk);
    src_ack = 1'b0;
  endtask

  task automatic pf_pulse();
    @(negedge clk);
    prefetch = 1'b1;
    @(negedge clk);
    prefetch = 1'b0;
  endtask

  task automatic prefill(input logic [31:0] seed);
    pf_pulse();
    feed(seed, WORDS, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_start = 1'b0; prefetch = 1'b0; rd_req = 1'b0;
    rd_narrow = 1'b0; src_ack = 1'b0; src_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!src_req && !rd_grant && !rd_stall, "R1 reset control outputs",
        {rd_grant, rd_stall, src_req}, '0);
    chk(rd_data == '0, "R1 reset data", rd_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!src_req && !rd_stall, "R1 idle after release", {rd_stall, src_req}, '0);

    // table of fill/read scenarios
    for (int i = 0; i < 4; i++) begin
      logic [VAL_W-1:0] exp;
      logic             use_pf, nar;
      logic [31:0]      seed;
      {use_pf, nar, seed} = VEC[i];
      exp = nar ? {{(VAL_W-WORD_W){1'b0}}, wgen(seed, 0)} : vgen(seed);
      if (use_pf) begin
        pf_pulse();
        #1 chk(src_req, "R7 prefetch starts fill", VAL_W'(src_req), 1);
        feed(seed, WORDS, 0);
        #1 chk(!src_req, "R3 request drops after eighth word", VAL_W'(src_req), 0);
        @(negedge clk);
        rd_req = 1'b1; rd_narrow = nar;
        #1 chk(rd_grant && !rd_stall, "R5 full cache served at once",
               VAL_W'({rd_grant, rd_stall}), 2);
        chk(rd_data == exp, "R2 R6 prefetched value", rd_data, exp);
      end else begin
        @(negedge clk);
        rd_req = 1'b1; rd_narrow = nar;
        #1 chk(rd_stall && !rd_grant, "R4 empty read stalls",
               VAL_W'({rd_grant, rd_stall}), 1);
        feed(seed, WORDS, 0);
        #1 chk(rd_grant && !rd_stall, "R4 grant after last word",
               VAL_W'({rd_grant, rd_stall}), 2);
        chk(rd_data == exp, "R2 R6 stalled read value", rd_data, exp);
      end
      @(negedge clk);
      rd_req = 1'b0; rd_narrow = 1'b0;
    end

    // R5: cache empty after a consuming read
    prefill(32'h1111_0001);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk);
    #1 chk(rd_stall && !rd_grant, "R5 cache empty after read",
           VAL_W'({rd_grant, rd_stall}), 1);
    chk(rd_data == '0, "R11 no data while stalled", rd_data, '0);
    feed(32'h2222_0002, WORDS, 0);
    #1 chk(rd_data == vgen(32'h2222_0002), "R5 refill delivered", rd_data, vgen(32'h2222_0002));
    @(negedge clk); rd_req = 1'b0;

    // R7: prefetch with a full cache
    prefill(32'h3333_0003);
    pf_pulse();
    #1 chk(!src_req, "R7 prefetch ignored when full", VAL_W'(src_req), 0);
    rd_req = 1'b1;
    #1 chk(rd_grant && rd_data == vgen(32'h3333_0003), "R7 cached value kept",
           rd_data, vgen(32'h3333_0003));
    @(negedge clk); rd_req = 1'b0;

    // R7 busy prefetch and R8 read joining a prefetch fill
    pf_pulse();
    feed(32'h4444_0004, 3, 0);
    prefetch = 1'b1; rd_req = 1'b1;
    #1 chk(rd_stall, "R8 read during prefetch stalls", VAL_W'(rd_stall), 1);
    @(negedge clk); prefetch = 1'b0;
    feed(32'h4444_0004, 5, 3);
    #1 chk(rd_grant && rd_data == vgen(32'h4444_0004), "R8 joins running fill",
           rd_data, vgen(32'h4444_0004));
    chk(!src_req, "R7 busy prefetch added no fill", VAL_W'(src_req), 0);
    @(negedge clk); rd_req = 1'b0;

    // R9: operation start discards a full cache
    prefill(32'h5555_0005);
    @(negedge clk); op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; rd_req = 1'b1;
    #1 chk(rd_stall && !rd_grant, "R9 cached value discarded",
           VAL_W'({rd_grant, rd_stall}), 1);
    feed(32'h6666_0006, WORDS, 0);
    #1 chk(rd_grant && rd_data == vgen(32'h6666_0006), "R9 fresh value after start",
           rd_data, vgen(32'h6666_0006));
    @(negedge clk); rd_req = 1'b0;

    // R10: operation start during a fill
    pf_pulse();
    feed(32'h7777_0007, 3, 0);
    op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; rd_req = 1'b1;
    #1 chk(src_req && rd_stall, "R10 dropped fill keeps requesting",
           VAL_W'({src_req, rd_stall}), 3);
    feed(32'h7777_0007, 5, 3);
    #1 chk(!rd_grant && rd_stall, "R10 drained words not delivered",
           VAL_W'({rd_grant, rd_stall}), 1);
    chk(!src_req, "R10 new fill waits for old one", VAL_W'(src_req), 0);
    feed(32'h8888_0008, WORDS, 0);
    #1 chk(rd_grant && rd_data == vgen(32'h8888_0008), "R10 only fresh words delivered",
           rd_data, vgen(32'h8888_0008));
    @(negedge clk); rd_req = 1'b0;
    #1 chk(rd_data == '0 && !rd_grant, "R11 data zero without grant", rd_data, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule